// File: doc/BRIEF.md
# Instruction-Boundary Event Priority Arbiter

This block sits beside an instruction pipeline's retire stage. On every cycle in which an instruction retires, it looks at all asynchronous conditions that want attention. These are system-management and init requests, a non-maskable interrupt, a local and a maskable interrupt line, a DMA hold request and debug traps. It grants at most one of them, as a single-cycle pulse on a one-hot grant bus. When the grant is an interrupt, it also supplies the vector to deliver. A companion flag tells the pipeline whether any event is still waiting, so the pipeline can skip the check at later boundaries when nothing is outstanding.

The arbiter keeps its own small amount of state:

- **Latched requests.** Init, system-management and non-maskable requests arrive as pulses and are held until they are serviced.
- **NMI block.** Taking a non-maskable interrupt blocks further ones until the core sends an unmask pulse.
- **Debug-trap register.** It collects trap status from retiring instructions. It also arms a single-step trap when the trap flag is set.
- **Inhibit window.** It blocks external interrupts, debug traps, or both, for the instruction after the one that requested it.

Top module: `evt_boundary_arb`

## Requirements
- R1: `grant` is one-hot or zero. Bit 0 is task-switch trap, bit 1 system-management, bit 2 init, bit 3 debug trap, bit 4 NMI, bit 5 local interrupt, bit 6 maskable interrupt, bit 7 DMA hold. A grant is only issued in a cycle with `boundary` high.
- R2: When several events are ready at one boundary, the lowest-numbered grant bit wins. The others stay pending for later boundaries.
- R3: System-management and init requests are latched from their raise pulses. They are granted only while `gif` is high and their `evt_mask` bit is clear (bit 0 system-management, bit 1 init). A grant clears that request.
- R4: NMI, local interrupt, maskable interrupt and DMA hold are not granted while `gif` is low or the interrupt inhibit window is active. `evt_mask` bits 2..5 mask NMI, local, maskable and hold.
- R5: An NMI grant drives `vec_out` = 2. It clears the NMI request and blocks further NMI grants until an `nmi_unmask` pulse.
- R6: A local or maskable interrupt grant drives `vec_out` = `iack_vec` in the same cycle. Local outranks maskable. All other grants drive `vec_out` = 0.
- R7: An `inh_req` records `inh_mask` (bit 0 interrupts, bit 1 debug traps) and the value `icount`+1. A class is blocked at boundaries with `icount` at or below that value, and only when all of the class's mask bits are recorded.
- R8: Debug-trap status is `dbg_src` ORed into the stored trap register at a boundary. Status bits 15..12 raise a debug-trap grant when debug traps are not inhibited. Bit 15, the task switch, takes grant bit 0 regardless of inhibit. When no trap is raised and debug traps are not inhibited, the register is cleared, so lower status bits are discarded.
- R9: A boundary with `tf` high sets single-step bit 14 in the trap register, so a debug-trap grant follows at the next boundary.
- R10: At a boundary with `gif` low, all trap status bits except bit 14 are discarded before any decision.
- R11: `async_pend` is high when any unmasked ready request exists while `gif` is high, when the stored trap register is non-zero, or when `hold_lvl` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Instruction-retire strobe |
| icount | input | CNT_W | Running retired-instruction count |
| smi_raise | input | 1 | Pulse: latch a system-management request |
| init_raise | input | 1 | Pulse: latch an init request |
| nmi_raise | input | 1 | Pulse: latch an NMI request |
| nmi_unmask | input | 1 | Pulse: lift the NMI block |
| lint_lvl | input | 1 | Local interrupt request level |
| intr_lvl | input | 1 | Maskable interrupt request level |
| hold_lvl | input | 1 | DMA hold request level |
| evt_mask | input | 6 | Per-event mask (smi, init, nmi, local, maskable, hold) |
| gif | input | 1 | Global interrupt-enable gate |
| tf | input | 1 | Trap flag (single-step) |
| dbg_src | input | DBG_W | Debug-trap status from the retiring instruction |
| inh_req | input | 1 | Open an inhibit window |
| inh_mask | input | 2 | Classes to inhibit (bit 0 interrupts, bit 1 debug) |
| iack_vec | input | VEC_W | Interrupt vector from the acknowledge source |
| grant | output | 8 | One-hot service grant |
| vec_out | output | VEC_W | Vector to deliver |
| async_pend | output | 1 | Some event still needs attention |

## Verification
The hardest situation to reach is a debug-only inhibit window that holds back an armed single-step trap while a maskable interrupt passes through at the same boundary. The trap must then still fire at the boundary after. The stimulus reaches it by raising `inh_req` with the debug class on the same retire cycle that `tf` is high. It then raises the interrupt line for exactly the next boundary. A second awkward case is a task-switch trap arriving while `gif` is low together with `tf`. The only thing left afterwards must be the single-step trap, which is checked by the grant bit at the next boundary.

// File: rtl/evtarb_pkg.sv
package evtarb_pkg;

    // grant bit positions, lowest index = highest priority
    localparam int GRANT_N  = 8;
    localparam int G_TSTRAP = 0;
    localparam int G_SMI    = 1;
    localparam int G_INIT   = 2;
    localparam int G_DBG    = 3;
    localparam int G_NMI    = 4;
    localparam int G_LINT   = 5;
    localparam int G_INTR   = 6;
    localparam int G_HOLD   = 7;

    typedef logic [GRANT_N-1:0] grant_t;

    // event request set; smi lands in bit 0
    typedef struct packed {
        logic hold;
        logic intr;
        logic lint;
        logic nmi;
        logic init;
        logic smi;
    } evt_t;

    localparam int EVT_N = $bits(evt_t);

    // inhibit classes
    localparam int               INH_W    = 2;
    localparam logic [INH_W-1:0] INH_INTR = 2'b01;
    localparam logic [INH_W-1:0] INH_DBG  = 2'b10;

    localparam int NMI_VECTOR = 2;

    // a class is blocked only when every one of its bits was recorded
    function automatic logic class_hit(input logic [INH_W-1:0] rec,
                                       input logic [INH_W-1:0] cls);
        return (rec & cls) == cls;
    endfunction

    // keep only the lowest set request bit
    function automatic grant_t pick_first(input grant_t req);
        grant_t g;
        logic   found;
        g     = '0;
        found = 1'b0;
        for (int i = 0; i < GRANT_N; i++) begin
            if (req[i] && !found) begin
                g[i]  = 1'b1;
                found = 1'b1;
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/evtarb_inhibit.sv
module evtarb_inhibit
    import evtarb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inh_req,
    input  logic [INH_W-1:0] inh_mask,
    input  logic [CNT_W-1:0] icount,
    output logic             intr_blk,
    output logic             dbg_blk
);

    logic [INH_W-1:0] mask_q;
    logic [CNT_W-1:0] limit_q;
    logic             in_window;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            limit_q <= '0;
        end else if (inh_req) begin
            mask_q  <= inh_mask;
            limit_q <= icount + CNT_W'(1);
        end
    end

    assign in_window = (icount <= limit_q);
    assign intr_blk  = in_window && class_hit(mask_q, INH_INTR);
    assign dbg_blk   = in_window && class_hit(mask_q, INH_DBG);

    // R7
    inh_record_chk: assert property (@(posedge clk) disable iff (rst)
        inh_req |=> (mask_q == $past(inh_mask)) && (limit_q == $past(icount) + CNT_W'(1)));

endmodule

// File: rtl/evtarb_pending.sv
module evtarb_pending (
    input  logic clk,
    input  logic rst,
    input  logic smi_raise,
    input  logic init_raise,
    input  logic nmi_raise,
    input  logic nmi_unmask,
    input  logic take_smi,
    input  logic take_init,
    input  logic take_nmi,
    output logic smi_q,
    output logic init_q,
    output logic nmi_q,
    output logic nmi_blk_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            smi_q     <= 1'b0;
            init_q    <= 1'b0;
            nmi_q     <= 1'b0;
            nmi_blk_q <= 1'b0;
        end else begin
            smi_q     <= smi_raise  | (smi_q  & ~take_smi);
            init_q    <= init_raise | (init_q & ~take_init);
            nmi_q     <= nmi_raise  | (nmi_q  & ~take_nmi);
            nmi_blk_q <= take_nmi   | (nmi_blk_q & ~nmi_unmask);
        end
    end

    // R5
    nmi_block_chk: assert property (@(posedge clk) disable iff (rst)
        take_nmi |=> nmi_blk_q);

    // R5
    nmi_once_chk: assert property (@(posedge clk) disable iff (rst)
        take_nmi |-> !nmi_blk_q);

    // R5
    nmi_consume_chk: assert property (@(posedge clk) disable iff (rst)
        (take_nmi && !nmi_raise) |=> !nmi_q);

    // R3
    smi_consume_chk: assert property (@(posedge clk) disable iff (rst)
        (take_smi && !smi_raise) |=> !smi_q);

    // R3
    init_consume_chk: assert property (@(posedge clk) disable iff (rst)
        (take_init && !init_raise) |=> !init_q);

endmodule

// File: rtl/evtarb_dbgtrap.sv
module evtarb_dbgtrap #(
    parameter int DBG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boundary,
    input  logic             gif,
    input  logic             tf,
    input  logic             dbg_blk,
    input  logic [DBG_W-1:0] src,
    input  logic             take_clear,
    input  logic             take_hold,
    output logic             ts_hit,
    output logic             fire,
    output logic [DBG_W-1:0] trap_q
);

    localparam int TS_POS    = DBG_W - 1;
    localparam int SS_POS    = DBG_W - 2;
    localparam int FIELD_LSB = DBG_W - 4;
    localparam logic [DBG_W-1:0] SS_MASK = {{(DBG_W-1){1'b0}}, 1'b1} << SS_POS;

    logic [DBG_W-1:0] raw;
    logic [DBG_W-1:0] eff;
    logic [DBG_W-1:0] nxt;

    assign raw    = trap_q | (boundary ? src : '0);
    assign eff    = gif ? raw : (raw & SS_MASK);
    assign ts_hit = eff[TS_POS];
    assign fire   = !dbg_blk && (|eff[DBG_W-1:FIELD_LSB]);

    always_comb begin
        if (take_clear)
            nxt = '0;
        else if (take_hold || dbg_blk)
            nxt = eff;
        else
            nxt = '0;
        if (tf)
            nxt[SS_POS] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            trap_q <= '0;
        else if (boundary)
            trap_q <= nxt;
    end

    // R9
    ss_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary && tf) |=> trap_q[SS_POS]);

    // R10
    gate_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary && !gif) |=> ((trap_q & ~SS_MASK) == '0));

    // R8
    low_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary && !dbg_blk && !take_hold) |=> (trap_q[FIELD_LSB-1:0] == '0));

endmodule

// File: rtl/evtarb_prio.sv
module evtarb_prio
    import evtarb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   boundary,
    input  logic   gif,
    input  logic   intr_blk,
    input  logic   ts_hit,
    input  logic   dbg_fire,
    input  evt_t   ready,
    output grant_t grant
);

    grant_t req;
    logic   ext_ok;

    assign ext_ok = gif && !intr_blk;

    always_comb begin
        req           = '0;
        req[G_TSTRAP] = ts_hit;
        req[G_SMI]    = ready.smi  && gif;
        req[G_INIT]   = ready.init && gif;
        req[G_DBG]    = dbg_fire;
        req[G_NMI]    = ready.nmi  && ext_ok;
        req[G_LINT]   = ready.lint && ext_ok;
        req[G_INTR]   = ready.intr && ext_ok;
        req[G_HOLD]   = ready.hold && ext_ok;
    end

    assign grant = boundary ? pick_first(req) : '0;

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R1
    grant_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> boundary);

    // R4
    ext_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (intr_blk || !gif) |-> (grant[G_HOLD:G_NMI] == '0));

    // R3
    sys_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (grant[G_SMI] || grant[G_INIT]) |-> gif);

endmodule

// File: rtl/evt_boundary_arb.sv
module evt_boundary_arb
    import evtarb_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DBG_W = 16,
    parameter int VEC_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               boundary,
    input  logic [CNT_W-1:0]   icount,
    input  logic               smi_raise,
    input  logic               init_raise,
    input  logic               nmi_raise,
    input  logic               nmi_unmask,
    input  logic               lint_lvl,
    input  logic               intr_lvl,
    input  logic               hold_lvl,
    input  logic [EVT_N-1:0]   evt_mask,
    input  logic               gif,
    input  logic               tf,
    input  logic [DBG_W-1:0]   dbg_src,
    input  logic               inh_req,
    input  logic [INH_W-1:0]   inh_mask,
    input  logic [VEC_W-1:0]   iack_vec,
    output logic [GRANT_N-1:0] grant,
    output logic [VEC_W-1:0]   vec_out,
    output logic               async_pend
);

    logic             intr_blk, dbg_blk;
    logic             smi_q, init_q, nmi_q, nmi_blk_q;
    logic             ts_hit, dbg_fire;
    logic [DBG_W-1:0] trap_q;
    evt_t             raw_evt;
    logic [EVT_N-1:0] ready_v;
    evt_t             ready;
    grant_t           grant_w;

    evtarb_inhibit #(.CNT_W(CNT_W)) u_inhibit (
        .clk      (clk),
        .rst      (rst),
        .inh_req  (inh_req),
        .inh_mask (inh_mask),
        .icount   (icount),
        .intr_blk (intr_blk),
        .dbg_blk  (dbg_blk)
    );

    evtarb_pending u_pending (
        .clk        (clk),
        .rst        (rst),
        .smi_raise  (smi_raise),
        .init_raise (init_raise),
        .nmi_raise  (nmi_raise),
        .nmi_unmask (nmi_unmask),
        .take_smi   (grant_w[G_SMI]),
        .take_init  (grant_w[G_INIT]),
        .take_nmi   (grant_w[G_NMI]),
        .smi_q      (smi_q),
        .init_q     (init_q),
        .nmi_q      (nmi_q),
        .nmi_blk_q  (nmi_blk_q)
    );

    evtarb_dbgtrap #(.DBG_W(DBG_W)) u_dbgtrap (
        .clk        (clk),
        .rst        (rst),
        .boundary   (boundary),
        .gif        (gif),
        .tf         (tf),
        .dbg_blk    (dbg_blk),
        .src        (dbg_src),
        .take_clear (grant_w[G_TSTRAP] | grant_w[G_DBG]),
        .take_hold  (grant_w[G_SMI] | grant_w[G_INIT]),
        .ts_hit     (ts_hit),
        .fire       (dbg_fire),
        .trap_q     (trap_q)
    );

    always_comb begin
        raw_evt      = '0;
        raw_evt.smi  = smi_q;
        raw_evt.init = init_q;
        raw_evt.nmi  = nmi_q & ~nmi_blk_q;
        raw_evt.lint = lint_lvl;
        raw_evt.intr = intr_lvl;
        raw_evt.hold = hold_lvl;
    end

    assign ready_v = raw_evt & ~evt_mask;
    assign ready   = evt_t'(ready_v);

    evtarb_prio u_prio (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .gif      (gif),
        .intr_blk (intr_blk),
        .ts_hit   (ts_hit),
        .dbg_fire (dbg_fire),
        .ready    (ready),
        .grant    (grant_w)
    );

    assign grant = grant_w;

    always_comb begin
        if (grant_w[G_NMI])
            vec_out = VEC_W'(NMI_VECTOR);
        else if (grant_w[G_LINT] || grant_w[G_INTR])
            vec_out = iack_vec;
        else
            vec_out = '0;
    end

    assign async_pend = (gif && (|ready_v)) || (|trap_q) || hold_lvl;

    // R11
    async_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary && tf) |=> async_pend);

endmodule

// File: tb/evt_boundary_arb_tb_top.sv
`timescale 1ns/1ps
module evt_boundary_arb_tb_top;
    import evtarb_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boundary = 1'b0;
    logic [31:0] icount = 32'd10;
    logic        smi_raise = 1'b0, init_raise = 1'b0, nmi_raise = 1'b0, nmi_unmask = 1'b0;
    logic        lint_lvl = 1'b0, intr_lvl = 1'b0, hold_lvl = 1'b0;
    logic [5:0]  evt_mask = '0;
    logic        gif = 1'b1, tf = 1'b0;
    logic [15:0] dbg_src = '0;
    logic        inh_req = 1'b0;
    logic [1:0]  inh_mask = '0;
    logic [7:0]  iack_vec = '0;
    logic [7:0]  grant;
    logic [7:0]  vec_out;
    logic        async_pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    evt_boundary_arb dut_i (
        .clk(clk), .rst(rst), .boundary(boundary), .icount(icount),
        .smi_raise(smi_raise), .init_raise(init_raise), .nmi_raise(nmi_raise),
        .nmi_unmask(nmi_unmask), .lint_lvl(lint_lvl), .intr_lvl(intr_lvl),
        .hold_lvl(hold_lvl), .evt_mask(evt_mask), .gif(gif), .tf(tf),
        .dbg_src(dbg_src), .inh_req(inh_req), .inh_mask(inh_mask),
        .iack_vec(iack_vec), .grant(grant), .vec_out(vec_out),
        .async_pend(async_pend)
    );

    typedef struct {
        logic [7:0] g;
        logic [7:0] v;
        logic       a;
        string      tag;
    } exp_t;

    exp_t sb[$];

    function automatic logic [7:0] gb(input int i);
        return 8'b1 << i;
    endfunction

    // driver: apply one cycle of stimulus and queue its expected result
    task automatic cyc(input logic bnd, input logic [7:0] eg, input logic [7:0] ev,
                       input logic ea, input string tag);
        exp_t e;
        boundary = bnd;
        e.g = eg; e.v = ev; e.a = ea; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        #1;
        smi_raise = 1'b0; init_raise = 1'b0; nmi_raise = 1'b0; nmi_unmask = 1'b0;
        inh_req = 1'b0; dbg_src = '0;
        if (bnd) icount = icount + 32'd1;
        boundary = 1'b0;
    endtask

    // monitor: compare mid-cycle against the scoreboard
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (grant !== e.g || vec_out !== e.v || async_pend !== e.a) begin
                fails++;
                $display("FAIL %s: grant=%b vec=%0d async=%b expected grant=%b vec=%0d async=%b",
                         e.tag, grant, vec_out, async_pend, e.g, e.v, e.a);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        cyc(0, 8'h00, 8'd0, 1'b0, "R11 reset idle");

        // R6 interrupt vectors and local-over-maskable, R2 hold last
        intr_lvl = 1; hold_lvl = 1; iack_vec = 8'h41;
        cyc(1, gb(G_INTR), 8'h41, 1'b1, "R6 maskable vector");
        lint_lvl = 1; iack_vec = 8'h55;
        cyc(1, gb(G_LINT), 8'h55, 1'b1, "R6 local before maskable");
        lint_lvl = 0; intr_lvl = 0;
        cyc(1, gb(G_HOLD), 8'd0, 1'b1, "R2 hold lowest");
        hold_lvl = 0;
        cyc(1, 8'h00, 8'd0, 1'b0, "R11 quiet after hold");

        // R1 no grant off boundary
        intr_lvl = 1;
        cyc(0, 8'h00, 8'd0, 1'b1, "R1 no grant without boundary");
        intr_lvl = 0;

        // R2 full ladder
        smi_raise = 1; init_raise = 1; nmi_raise = 1; intr_lvl = 1; iack_vec = 8'h30;
        cyc(0, 8'h00, 8'd0, 1'b1, "R2 setup");
        cyc(1, gb(G_SMI),  8'd0,  1'b1, "R2 smi first");
        cyc(1, gb(G_INIT), 8'd0,  1'b1, "R2 init second");
        cyc(1, gb(G_NMI),  8'd2,  1'b1, "R5 nmi vector 2");
        cyc(1, gb(G_INTR), 8'h30, 1'b1, "R2 interrupt after nmi");
        intr_lvl = 0;
        cyc(1, 8'h00, 8'd0, 1'b0, "R2 ladder drained");

        // R5 nmi block and unmask
        nmi_raise = 1;
        cyc(0, 8'h00, 8'd0, 1'b0, "R5 raise while blocked");
        cyc(1, 8'h00, 8'd0, 1'b0, "R5 blocked nmi not granted");
        nmi_unmask = 1;
        cyc(0, 8'h00, 8'd0, 1'b0, "R5 unmask pulse");
        cyc(1, gb(G_NMI), 8'd2, 1'b1, "R5 nmi after unmask");
        nmi_unmask = 1;
        cyc(0, 8'h00, 8'd0, 1'b0, "R5 consumed");

        // R3 / R4 global gate
        gif = 0; smi_raise = 1; intr_lvl = 1; iack_vec = 8'h31;
        cyc(0, 8'h00, 8'd0, 1'b0, "R4 gate low setup");
        cyc(1, 8'h00, 8'd0, 1'b0, "R3 smi held by gate");
        cyc(1, 8'h00, 8'd0, 1'b0, "R4 interrupt held by gate");
        hold_lvl = 1;
        cyc(1, 8'h00, 8'd0, 1'b1, "R4 hold held by gate, R11 raw hold");
        gif = 1; hold_lvl = 0;
        cyc(1, gb(G_SMI),  8'd0,  1'b1, "R3 smi after gate opens");
        cyc(1, gb(G_INTR), 8'h31, 1'b1, "R4 interrupt after gate opens");
        intr_lvl = 0;
        cyc(0, 8'h00, 8'd0, 1'b0, "R3 gate idle");

        // R3 init mask
        evt_mask = 6'b000010; init_raise = 1;
        cyc(0, 8'h00, 8'd0, 1'b0, "R3 init raise masked");
        cyc(1, 8'h00, 8'd0, 1'b0, "R3 masked init not granted");
        evt_mask = '0;
        cyc(1, gb(G_INIT), 8'd0, 1'b1, "R3 init after unmask");
        cyc(1, 8'h00, 8'd0, 1'b0, "R3 init consumed");

        // R7 interrupt shadow
        inh_req = 1; inh_mask = INH_INTR;
        cyc(1, 8'h00, 8'd0, 1'b0, "R7 shadow opened");
        intr_lvl = 1; iack_vec = 8'h66;
        cyc(1, 8'h00, 8'd0, 1'b1, "R7 shadow blocks interrupt");
        cyc(1, gb(G_INTR), 8'h66, 1'b1, "R7 shadow expired");
        intr_lvl = 0;
        cyc(0, 8'h00, 8'd0, 1'b0, "R7 idle");

        // R9 single step
        tf = 1;
        cyc(1, 8'h00, 8'd0, 1'b0, "R9 step armed");
        tf = 0;
        cyc(1, gb(G_DBG), 8'd0, 1'b1, "R9 step fires next boundary");
        cyc(1, 8'h00, 8'd0, 1'b0, "R9 step one shot");

        // R7 debug-only shadow lets interrupt through
        inh_req = 1; inh_mask = INH_DBG; tf = 1;
        cyc(1, 8'h00, 8'd0, 1'b0, "R7 debug shadow opened");
        tf = 0; intr_lvl = 1; iack_vec = 8'h77;
        cyc(1, gb(G_INTR), 8'h77, 1'b1, "R7 debug held, interrupt passes");
        intr_lvl = 0;
        cyc(1, gb(G_DBG), 8'd0, 1'b1, "R7 debug trap after shadow");
        cyc(0, 8'h00, 8'd0, 1'b0, "R8 trap register cleared");

        // R8 low status bits vs trap field
        dbg_src = 16'h0003;
        cyc(1, 8'h00, 8'd0, 1'b0, "R8 low bits raise nothing");
        cyc(0, 8'h00, 8'd0, 1'b0, "R8 low bits discarded");
        dbg_src = 16'h2000;
        cyc(1, gb(G_DBG), 8'd0, 1'b0, "R8 field bit raises trap");
        cyc(0, 8'h00, 8'd0, 1'b0, "R8 trap consumed");

        // R8 task switch above smi
        smi_raise = 1;
        cyc(0, 8'h00, 8'd0, 1'b0, "R8 smi setup");
        dbg_src = 16'h8000;
        cyc(1, gb(G_TSTRAP), 8'd0, 1'b1, "R8 task switch first");
        cyc(1, gb(G_SMI),    8'd0, 1'b1, "R8 smi follows");
        cyc(0, 8'h00, 8'd0, 1'b0, "R8 drained");

        // R10 gate discards all but single step
        gif = 0; tf = 1; dbg_src = 16'hB000;
        cyc(1, 8'h00, 8'd0, 1'b0, "R10 status discarded under gate");
        gif = 1; tf = 0;
        cyc(1, gb(G_DBG), 8'd0, 1'b1, "R10 only single step survives");
        cyc(0, 8'h00, 8'd0, 1'b0, "R10 idle");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule